// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block runs a 12-bit sampling converter that has a parallel output bus and no pipeline delay. At a programmable sample period it raises a start-convert pulse of programmable width, then follows the converter's busy line (EOC). When EOC falls it waits a settle delay and latches the 12-bit word. Each captured word leaves on a valid/ready stream, both as the raw offset-binary code and as a two's-complement copy. The block also drives the converter's active-low output-enable line.

EOC and the data bus pass through two-flop synchronizers, and the falling edge of EOC is detected on the synchronized copy. The block never starts a conversion while the converter reports busy. A conversion whose EOC never falls ends in a sticky timeout flag. A sample that arrives while the stream still holds an unaccepted word is dropped and raises a sticky overrun flag, so the conversion rhythm is never stalled. All timing settings are in system clock cycles. They are sized for a 100 MHz clock, where 5 to 10 cycles spans the allowed 50 to 100 ns pulse and 20 cycles is the 200 ns minimum sample period.

Top module: `adc_conv_seq`

## Requirements
- R1: The start-convert pulse stays high for exactly cfg_pulse_i cycles, clamped into the range 5 to 10 cycles (a setting of 2 gives 5, a setting of 15 gives 10).
- R2: No start-convert pulse rises while the synchronized EOC is high. A sample tick seen while EOC is high is dropped, and starts resume on the first tick after EOC goes low.
- R3: While run_i is high and each conversion completes within the period, successive start-pulse rising edges are exactly max(cfg_period_i, 20) cycles apart.
- R4: adc_oe_no is low from the cycle the start pulse rises until the capture, including the whole start pulse. It is high while idle and during reset.
- R5: smp_valid_o rises on the (3 + S)-th rising clock edge after EOC goes low, where S is cfg_settle_i with a floor of 2 cycles. The word is taken from the synchronized data bus.
- R6: There is no pipeline offset: the k-th word delivered after reset is the result of the k-th conversion.
- R7: smp_raw_o carries the 12-bit offset-binary code, where 0x800 is zero, 0x000 is negative full scale and 0xFFF is positive full scale minus one LSB. smp_twos_o equals smp_raw_o minus 0x800 modulo 4096, so 0x800 maps to 0x000, 0x000 to 0x800 and 0xFFF to 0x7FF.
- R8: While smp_valid_o is high and smp_ready_i is low, the word holds steady. A capture in that state is dropped and sets overrun_o, which stays high until reset.
- R9: If EOC has not fallen after cfg_timeout_i cycles counted from the start, timeout_o is set and stays high until reset. The block returns to idle without emitting a word and keeps issuing starts.
- R10: After reset, adc_convst_o, smp_valid_o, timeout_o and overrun_o are low and adc_oe_no is high.
- R11: While run_i is low no start pulse is issued. The period timer restarts from zero when run_i rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables periodic conversions |
| cfg_period_i | input | 16 | Sample period in cycles (floor 20) |
| cfg_pulse_i | input | 16 | Start pulse width in cycles (clamped 5..10) |
| cfg_settle_i | input | 16 | Delay from detected EOC fall to capture (floor 2) |
| cfg_timeout_i | input | 16 | Cycles from start before a missing EOC fall is flagged |
| adc_eoc_i | input | 1 | Converter busy line, asynchronous |
| adc_data_i | input | 12 | Converter output bus, asynchronous |
| adc_convst_o | output | 1 | Start-convert pulse, converter starts on its rising edge |
| adc_oe_no | output | 1 | Converter output enable, active low |
| smp_valid_o | output | 1 | Stream word valid |
| smp_ready_i | input | 1 | Stream consumer ready |
| smp_raw_o | output | 12 | Offset-binary sample |
| smp_twos_o | output | 12 | Two's-complement sample |
| timeout_o | output | 1 | Sticky missing-EOC flag |
| overrun_o | output | 1 | Sticky dropped-sample flag |

## Verification
A word is due on the (3 + S)-th rising edge after EOC drops: two synchronizer stages, one edge-detect register, then S settle cycles. The bench drives EOC at a falling edge, counts rising edges, and samples one falling edge before and one after the due edge. A start pulse rises on the edge after a sample tick, and ticks come every max(period, 20) cycles. Timeout is flagged on the edge after the start counter reaches the setting. The bench records rise and fall times of the start pulse on falling edges and compares period and width in whole cycles. The backpressure test leans on the fixed 20-cycle capture spacing, so it can pick sampling points that never land on a capture edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned ADC_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_WAIT   = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned CW      = 16,
  parameter int unsigned PER_MIN = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] period_i,
  output logic          tick_o
);
  localparam logic [CW-1:0] PerLo = CW'(PER_MIN);

  logic [CW-1:0] per_eff, cnt_q;
  logic          last;

  assign per_eff = (period_i < PerLo) ? PerLo : period_i;
  assign last    = (cnt_q >= per_eff - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = run_i & last;
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm #(
  parameter int unsigned CW         = 16,
  parameter int unsigned PW_MIN     = 5,
  parameter int unsigned PW_MAX     = 10,
  parameter int unsigned SETTLE_MIN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          eoc_s_i,
  input  logic [CW-1:0] pulse_i,
  input  logic [CW-1:0] settle_i,
  input  logic [CW-1:0] timeout_i,
  output logic          convst_o,
  output logic          oe_no,
  output logic          capture_o,
  output logic          timeout_o
);
  localparam logic [CW-1:0] PwLo = CW'(PW_MIN);
  localparam logic [CW-1:0] PwHi = CW'(PW_MAX);
  localparam logic [CW-1:0] StLo = CW'(SETTLE_MIN);

  adc_seq_pkg::seq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, tcnt_q, pw_eff, st_eff;
  logic          eoc_d1_q, eoc_fall, tmo_hit;
  logic          convst_q, oe_nq, tmo_q;

  always_comb begin
    if (pulse_i < PwLo)      pw_eff = PwLo;
    else if (pulse_i > PwHi) pw_eff = PwHi;
    else                     pw_eff = pulse_i;
  end

  assign st_eff   = (settle_i < StLo) ? StLo : settle_i;
  assign eoc_fall = eoc_d1_q & ~eoc_s_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q + CW'(1);
    capture_o = 1'b0;
    tmo_hit   = 1'b0;
    unique case (st_q)
      adc_seq_pkg::ST_IDLE: begin
        cnt_d = '0;
        // busy guard: never start while converter reports EOC high
        if (tick_i && !eoc_s_i) st_d = adc_seq_pkg::ST_PULSE;
      end
      adc_seq_pkg::ST_PULSE: begin
        if (cnt_q == pw_eff - CW'(1)) st_d = adc_seq_pkg::ST_WAIT;
      end
      adc_seq_pkg::ST_WAIT: begin
        cnt_d = '0;
        if (eoc_fall) st_d = adc_seq_pkg::ST_SETTLE;
        else if (tcnt_q >= timeout_i) begin
          st_d    = adc_seq_pkg::ST_IDLE;
          tmo_hit = 1'b1;
        end
      end
      adc_seq_pkg::ST_SETTLE: begin
        if (cnt_q == st_eff - CW'(1)) begin
          st_d      = adc_seq_pkg::ST_IDLE;
          capture_o = 1'b1;
        end
      end
      default: st_d = adc_seq_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= adc_seq_pkg::ST_IDLE;
      cnt_q    <= '0;
      tcnt_q   <= '0;
      eoc_d1_q <= 1'b0;
      convst_q <= 1'b0;
      oe_nq    <= 1'b1;
      tmo_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      tcnt_q   <= (st_q == adc_seq_pkg::ST_IDLE) ? '0 : tcnt_q + CW'(1);
      eoc_d1_q <= eoc_s_i;
      convst_q <= (st_d == adc_seq_pkg::ST_PULSE);
      oe_nq    <= (st_d == adc_seq_pkg::ST_IDLE);
      if (tmo_hit) tmo_q <= 1'b1;
    end
  end

  assign convst_o  = convst_q;
  assign oe_no     = oe_nq;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] twos_o,
  output logic          overrun_o
);
  logic          valid_q, ovr_q, slot_free;
  logic [DW-1:0] raw_q;

  assign slot_free = ~valid_q | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      raw_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (capture_i && slot_free) begin
        valid_q <= 1'b1;
        raw_q   <= data_i;
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
      // drop the new word rather than stall the converter
      if (capture_i && !slot_free) ovr_q <= 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign raw_o     = raw_q;
  assign twos_o    = {~raw_q[DW-1], raw_q[DW-2:0]};
  assign overrun_o = ovr_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned DATA_W     = adc_seq_pkg::ADC_W,
  parameter int unsigned CW         = 16,
  parameter int unsigned PW_MIN     = 5,
  parameter int unsigned PW_MAX     = 10,
  parameter int unsigned SETTLE_MIN = 2,
  parameter int unsigned PER_MIN    = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CW-1:0]     cfg_period_i,
  input  logic [CW-1:0]     cfg_pulse_i,
  input  logic [CW-1:0]     cfg_settle_i,
  input  logic [CW-1:0]     cfg_timeout_i,
  input  logic              adc_eoc_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_convst_o,
  output logic              adc_oe_no,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [DATA_W-1:0] smp_raw_o,
  output logic [DATA_W-1:0] smp_twos_o,
  output logic              timeout_o,
  output logic              overrun_o
);
  logic              eoc_s, tick, capture;
  logic [DATA_W-1:0] data_s;

  adc_sync #(.W(1)) u_sync_eoc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (adc_eoc_i),
    .q_o   (eoc_s)
  );

  adc_sync #(.W(DATA_W)) u_sync_data (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (adc_data_i),
    .q_o   (data_s)
  );

  adc_rate_timer #(.CW(CW), .PER_MIN(PER_MIN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .period_i(cfg_period_i),
    .tick_o  (tick)
  );

  adc_conv_fsm #(
    .CW(CW), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX), .SETTLE_MIN(SETTLE_MIN)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .eoc_s_i  (eoc_s),
    .pulse_i  (cfg_pulse_i),
    .settle_i (cfg_settle_i),
    .timeout_i(cfg_timeout_i),
    .convst_o (adc_convst_o),
    .oe_no    (adc_oe_no),
    .capture_o(capture),
    .timeout_o(timeout_o)
  );

  adc_out_stage #(.DW(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .data_i   (data_s),
    .ready_i  (smp_ready_i),
    .valid_o  (smp_valid_o),
    .raw_o    (smp_raw_o),
    .twos_o   (smp_twos_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int unsigned DW     = 12,
  parameter int unsigned PW_MIN = 5,
  parameter int unsigned PW_MAX = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          convst_i,
  input logic          oe_ni,
  input logic          eoc_s_i,
  input logic          valid_i,
  input logic          ready_i,
  input logic [DW-1:0] raw_i,
  input logic          tmo_i,
  input logic          ovr_i
);
  logic [15:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_q <= '0;
    else if (convst_i) hi_q <= hi_q + 16'd1;
    else               hi_q <= '0;
  end

  a_r1_pulse_not_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_i |-> (hi_q < 16'(PW_MAX)));

  a_r1_pulse_not_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_i) |-> (hi_q >= 16'(PW_MIN)));

  a_r2_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_i) |-> !$past(eoc_s_i));

  a_r4_oe_during_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_i |-> !oe_ni);

  a_r8_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> (valid_i && $stable(raw_i)));

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> ovr_i);

  a_r9_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> tmo_i);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .DW(DATA_W), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .convst_i(adc_convst_o),
  .oe_ni   (adc_oe_no),
  .eoc_s_i (eoc_s),
  .valid_i (smp_valid_o),
  .ready_i (smp_ready_i),
  .raw_i   (smp_raw_o),
  .tmo_i   (timeout_o),
  .ovr_i   (overrun_o)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] cfg_period = 16'd20, cfg_pulse = 16'd5, cfg_settle = 16'd3, cfg_timeout = 16'd100;
  logic        eoc_pin;
  logic [11:0] data_pin;
  logic        convst, oe_n, valid, tmo, ovr;
  logic        ready = 1'b1;
  logic [11:0] raw, twos;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  adc_conv_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .cfg_period_i(cfg_period), .cfg_pulse_i(cfg_pulse),
    .cfg_settle_i(cfg_settle), .cfg_timeout_i(cfg_timeout),
    .adc_eoc_i(eoc_pin), .adc_data_i(data_pin),
    .adc_convst_o(convst), .adc_oe_no(oe_n),
    .smp_valid_o(valid), .smp_ready_i(ready),
    .smp_raw_o(raw), .smp_twos_o(twos),
    .timeout_o(tmo), .overrun_o(ovr)
  );

  // converter model
  logic [11:0] smp_tab [8];
  logic        eoc_mdl = 1'b0, eoc_force = 1'b0, model_on = 1'b1, conv_prev = 1'b0;
  logic [11:0] held = 12'h000;
  int          conv_left = 0, conv_len = 8, conv_idx = 0;

  initial begin
    smp_tab[0] = 12'h800; smp_tab[1] = 12'h000; smp_tab[2] = 12'hFFF; smp_tab[3] = 12'h123;
    smp_tab[4] = 12'h7FF; smp_tab[5] = 12'h801; smp_tab[6] = 12'hA5A; smp_tab[7] = 12'h001;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      eoc_mdl <= 1'b0; conv_left <= 0; conv_idx <= 0; conv_prev <= 1'b0; held <= 12'h000;
    end else begin
      conv_prev <= convst;
      if (convst && !conv_prev && model_on) begin
        eoc_mdl   <= 1'b1;
        conv_left <= conv_len;
      end else if (conv_left > 0) begin
        conv_left <= conv_left - 1;
        if (conv_left == 1) begin
          eoc_mdl  <= 1'b0;
          held     <= smp_tab[conv_idx % 8];
          conv_idx <= conv_idx + 1;
        end
      end
    end
  end

  assign eoc_pin  = eoc_mdl | eoc_force;
  assign data_pin = oe_n ? 12'h3C3 : (eoc_mdl ? 12'hE1E : held);

  // start pulse monitor
  int   cyc = 0;
  int   rise_cnt = 0, fall_cnt = 0, last_w = 0, hi_run = 0;
  int   rise_t [64];
  logic mon_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      rise_cnt <= 0; fall_cnt <= 0; hi_run <= 0; mon_prev <= 1'b0;
    end else begin
      mon_prev <= convst;
      if (convst) hi_run <= hi_run + 1;
      if (convst && !mon_prev) begin
        rise_t[rise_cnt % 64] <= cyc;
        rise_cnt <= rise_cnt + 1;
      end
      if (!convst && mon_prev) begin
        last_w   <= hi_run;
        hi_run   <= 0;
        fall_cnt <= fall_cnt + 1;
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic r, int per, int pw, int st, int tmo_c, int clen);
    @(negedge clk);
    rst_n = 1'b0; run = r; ready = 1'b1; eoc_force = 1'b0; model_on = 1'b1;
    cfg_period = 16'(per); cfg_pulse = 16'(pw); cfg_settle = 16'(st);
    cfg_timeout = 16'(tmo_c); conv_len = clen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (valid) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_rises(int n, int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rise_cnt >= n) break;
    end
  endtask

  task automatic wait_falls(int n, int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (fall_cnt >= n) break;
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 20, 5, 3, 100, 8);
    @(negedge clk);
    chk("R10 convst", int'(convst), 0);
    chk("R10 oe_n", int'(oe_n), 1);
    chk("R10 valid", int'(valid), 0);
    chk("R10 timeout", int'(tmo), 0);
    chk("R10 overrun", int'(ovr), 0);
  endtask

  task automatic t_stream();
    bit ok;
    do_reset(1'b1, 20, 5, 3, 100, 8);
    wait_rises(1, 40);
    chk("R4 oe low during pulse", int'(oe_n), 0);
    for (int k = 0; k < 8; k++) begin
      logic [11:0] exp_raw;
      exp_raw = smp_tab[k];
      wait_valid(40, ok);
      chk("R6 word arrived", int'(ok), 1);
      chk("R6 R7 raw order", int'(raw), int'(exp_raw));
      chk("R7 twos", int'(twos), int'(12'(exp_raw - 12'h800)));
      chk("R4 oe high after capture", int'(oe_n), 1);
    end
  endtask

  task automatic t_pulse_width(int set_w, int exp_w);
    do_reset(1'b1, 40, set_w, 3, 100, 14);
    wait_falls(1, 80);
    chk("R1 pulse width", last_w, exp_w);
  endtask

  task automatic t_period(int set_p, int exp_p);
    do_reset(1'b1, set_p, 5, 3, 100, 8);
    wait_rises(3, 200);
    chk("R3 period", rise_t[2] - rise_t[1], exp_p);
  endtask

  task automatic t_settle(int set_s, int eff_s);
    do_reset(1'b1, 20, 5, set_s, 100, 8);
    @(negedge eoc_pin);
    repeat (2 + eff_s) @(posedge clk);
    @(negedge clk);
    chk("R5 not yet valid", int'(valid), 0);
    @(negedge clk);
    chk("R5 valid due", int'(valid), 1);
    chk("R5 word", int'(raw), int'(smp_tab[0]));
  endtask

  task automatic t_busy_guard();
    do_reset(1'b1, 20, 5, 3, 100, 8);
    eoc_force = 1'b1;
    repeat (80) @(negedge clk);
    chk("R2 no start while busy", rise_cnt, 0);
    eoc_force = 1'b0;
    wait_rises(1, 30);
    chk("R2 starts resume", rise_cnt, 1);
  endtask

  task automatic t_backpressure();
    bit ok;
    do_reset(1'b1, 20, 5, 3, 100, 8);
    ready = 1'b0;
    wait_valid(60, ok);
    chk("R8 first word", int'(raw), int'(smp_tab[0]));
    repeat (30) @(negedge clk);
    chk("R8 held valid", int'(valid), 1);
    chk("R8 held word", int'(raw), int'(smp_tab[0]));
    chk("R8 overrun set", int'(ovr), 1);
    ready = 1'b1;
    @(negedge clk);
    chk("R8 accepted", int'(valid), 0);
    wait_valid(40, ok);
    chk("R8 dropped word skipped", int'(raw), int'(smp_tab[2]));
    repeat (5) @(negedge clk);
    chk("R8 overrun sticky", int'(ovr), 1);
  endtask

  task automatic t_timeout();
    int seen;
    do_reset(1'b1, 40, 5, 3, 30, 8);
    model_on = 1'b0;
    wait_rises(1, 60);
    repeat (20) @(negedge clk);
    chk("R9 not early", int'(tmo), 0);
    repeat (15) @(negedge clk);
    chk("R9 flagged", int'(tmo), 1);
    chk("R9 no word", int'(valid), 0);
    seen = rise_cnt;
    wait_rises(seen + 1, 60);
    chk("R9 starts continue", int'(rise_cnt > seen), 1);
    chk("R9 sticky", int'(tmo), 1);
  endtask

  task automatic t_run_gate();
    do_reset(1'b0, 20, 5, 3, 100, 8);
    repeat (80) @(negedge clk);
    chk("R11 idle when stopped", rise_cnt, 0);
    run = 1'b1;
    wait_rises(1, 25);
    chk("R11 starts on run", rise_cnt, 1);
  endtask

  initial begin
    t_reset_state();
    t_stream();
    t_pulse_width(2, 5);
    t_pulse_width(7, 7);
    t_pulse_width(15, 10);
    t_period(25, 25);
    t_period(8, 20);
    t_settle(3, 3);
    t_settle(1, 2);
    t_busy_guard();
    t_backpressure();
    t_timeout();
    t_run_gate();
    summary();
    $finish;
  end
endmodule